// File: doc/BRIEF.md
# Bidirectional Port with Pin-Change and Edge Interrupts

This block is an 8-bit general-purpose I/O port for a small microcontroller core. Each bit has two latches: an output value latch and a direction latch. The core loads each of them from its internal write bus using its own strobe. The port drives per-pin output-enable, output-value and weak-pull-up-enable signals to a pad model. It receives the pad levels back through a multi-stage synchronizer.

Two interrupt sources live in the port:

- **Change flag.** The upper bits (7..4) are watched for level changes against a reference. The reference is captured every time the core reads the port. Any mismatch on a monitored input bit sets one sticky change flag.
- **Edge flag.** Bit 0 doubles as an external interrupt line. It has its own sticky flag, and its active edge is selectable.

Both flags are cleared by software strobes. The intended service sequence is to read the port first, which ends the mismatch, and then clear the flag.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset all direction bits are 1 (all pins inputs), so pin_oe is 0x00 and pin_pu is 0x00 while pu_en_n is 1. The output latch is 0x00, and chg_flag and ext_flag are 0.
- R2: When wr_data is high at a clock edge, the output latch takes bus_wdata, and pin_out shows it after that edge. Without the strobe, pin_out does not change.
- R3: When wr_dir is high at a clock edge, the direction latch takes bus_wdata. A direction bit of 0 drives pin_oe for that bit to 1, and a bit of 1 drives it to 0.
- R4: pin_pu[i] is 1 exactly when direction bit i is 1 and the global active-low enable pu_en_n is 0.
- R5: With rd_port high, rd_data returns the synchronized pin level for each bit whose direction is 1, and the output latch value for each bit whose direction is 0. A pin change shows on rd_data after two clock edges.
- R6: A change on a monitored input pin (bits 7..4) away from the reference sets chg_flag. The flag is visible after the fourth clock edge following the pin change.
- R7: Pins 3..0 never affect chg_flag.
- R8: A monitored bit whose direction bit is 0 is left out of the mismatch comparison. If its direction returns to 1 while its pin differs from the reference, chg_flag sets.
- R9: chg_flag stays set until a chg_clr strobe. While a mismatch still exists, setting takes priority over the clear.
- R10: A cycle with rd_port high loads the reference with the current synchronized levels of bits 7..4. This ends the mismatch, so a following chg_clr leaves chg_flag at 0.
- R11: ext_flag sets on a rising edge of pin 0 when ext_rise is 1, and on a falling edge when ext_rise is 0. It is visible after the third clock edge following the pin change. The opposite edge does not set it. It stays set until ext_clr.
- R12: rd_port takes priority over rd_dir. With rd_dir alone, rd_data returns the direction latch. With neither strobe, rd_data is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wdata | input | 8 | Internal write bus |
| wr_data | input | 1 | Output latch write strobe |
| wr_dir | input | 1 | Direction latch write strobe |
| rd_port | input | 1 | Port read strobe; also captures the change reference |
| rd_dir | input | 1 | Direction read strobe |
| rd_data | output | 8 | Read data, combinational from the strobes |
| pu_en_n | input | 1 | Global pull-up enable, active low |
| ext_rise | input | 1 | Edge select for bit 0: 1 selects rising, 0 selects falling |
| chg_clr | input | 1 | Clear strobe for chg_flag |
| ext_clr | input | 1 | Clear strobe for ext_flag |
| pin_in | input | 8 | Pad levels, asynchronous |
| pin_out | output | 8 | Output value to the pads |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Weak pull-up enable per pin |
| chg_flag | output | 1 | Sticky pin-change interrupt flag |
| ext_flag | output | 1 | Sticky bit-0 edge interrupt flag |

## Verification
- A stale or mis-captured change reference shows up on chg_flag four edges after the pin moves: either a spurious set after a port read, or no set at all.
- A wrong direction latch appears at once on pin_oe and pin_pu, and on the next port read, where input and output bits swap sources.
- A lost edge-detector history bit shows within three edges, as ext_flag setting on the wrong polarity or never setting.
- The stimulus therefore checks each flag on the exact cycle before and after its expected set point.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_DIR  = 2'd1,
      RSEL_PORT = 2'd2
   } rsel_e;

   // port read outranks direction read
   function automatic rsel_e pick_read(input logic rp, input logic rd);
      if (rp)      return RSEL_PORT;
      else if (rd) return RSEL_DIR;
      else         return RSEL_NONE;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) st[s] <= '0;
            else        st[s] <= st[s-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
   parameter int N            = 4,
   parameter bit SAMPLE_STAGE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] mon_en,
   input  logic         capture,
   input  logic         clr,
   output logic         flag
);
   logic [N-1:0] ref_q;
   logic [N-1:0] samp;
   logic         mismatch;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       ref_q <= '0;
      else if (capture) ref_q <= lvl;

   if (SAMPLE_STAGE) begin : g_samp_reg
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) samp <= '0;
         else        samp <= lvl;
   end else begin : g_samp_thru
      assign samp = lvl;
   end

   assign mismatch = |((samp ^ ref_q) & mon_en);

   // a live mismatch outranks the clear
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        flag <= 1'b0;
      else if (mismatch) flag <= 1'b1;
      else if (clr)      flag <= 1'b0;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   input  logic clr,
   output logic flag
);
   logic prev;
   logic hit;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;

   assign hit = rise_sel ? (lvl & ~prev) : (~lvl & prev);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)   flag <= 1'b0;
      else if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
   parameter int WIDTH        = 8,
   parameter int CHG_LO       = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int EXT_BIT      = 0,
   parameter bit SAMPLE_STAGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_wdata,
   input  logic             wr_data,
   input  logic             wr_dir,
   input  logic             rd_port,
   input  logic             rd_dir,
   output logic [WIDTH-1:0] rd_data,
   input  logic             pu_en_n,
   input  logic             ext_rise,
   input  logic             chg_clr,
   input  logic             ext_clr,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] pin_out,
   output logic [WIDTH-1:0] pin_oe,
   output logic [WIDTH-1:0] pin_pu,
   output logic             chg_flag,
   output logic             ext_flag
);
   import gpio_port_pkg::*;

   localparam int NCHG = WIDTH - CHG_LO;

   if (WIDTH < 1)            begin : g_bad_w   $error("WIDTH must be positive"); end
   if (CHG_LO >= WIDTH)      begin : g_bad_chg $error("CHG_LO must be below WIDTH"); end
   if (SYNC_STAGES < 2)      begin : g_bad_syn $error("SYNC_STAGES must be at least 2"); end
   if (EXT_BIT >= WIDTH)     begin : g_bad_ext $error("EXT_BIT must be below WIDTH"); end

   logic [WIDTH-1:0] data_q;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] pin_s;
   logic [WIDTH-1:0] port_view;
   rsel_e            rsel;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       data_q <= '0;
      else if (wr_data) data_q <= bus_wdata;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      dir_q <= '1;
      else if (wr_dir) dir_q <= bus_wdata;

   gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_s)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign port_view[i] = dir_q[i] ? pin_s[i] : data_q[i];
      assign pin_oe[i]    = ~dir_q[i];
      assign pin_pu[i]    = dir_q[i] & ~pu_en_n;
   end

   assign pin_out = data_q;

   always_comb begin
      rsel = pick_read(rd_port, rd_dir);
      unique case (rsel)
         RSEL_PORT: rd_data = port_view;
         RSEL_DIR:  rd_data = dir_q;
         default:   rd_data = '0;
      endcase
   end

   gpio_chg_det #(.N(NCHG), .SAMPLE_STAGE(SAMPLE_STAGE)) u_chg (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (pin_s[WIDTH-1:CHG_LO]),
      .mon_en  (dir_q[WIDTH-1:CHG_LO]),
      .capture (rd_port),
      .clr     (chg_clr),
      .flag    (chg_flag)
   );

   gpio_edge_irq u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_s[EXT_BIT]),
      .rise_sel (ext_rise),
      .clr      (ext_clr),
      .flag     (ext_flag)
   );
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] bus_wdata,
   input logic         wr_data,
   input logic         wr_dir,
   input logic         pu_en_n,
   input logic         chg_clr,
   input logic         ext_clr,
   input logic [W-1:0] pin_out,
   input logic [W-1:0] pin_oe,
   input logic [W-1:0] pin_pu,
   input logic         chg_flag,
   input logic         ext_flag
);
   AST_DATA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> pin_out == $past(bus_wdata)); // R2
   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_data |=> $stable(pin_out)); // R2
   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pin_oe == ~$past(bus_wdata)); // R3
   AST_PU_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu & pin_oe) == '0); // R4
   AST_PU_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      pu_en_n |-> pin_pu == '0); // R4
   AST_CHG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      chg_flag && !chg_clr |=> chg_flag); // R9
   AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ext_flag && !ext_clr |=> ext_flag); // R11
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wdata (bus_wdata),
   .wr_data   (wr_data),
   .wr_dir    (wr_dir),
   .pu_en_n   (pu_en_n),
   .chg_clr   (chg_clr),
   .ext_clr   (ext_clr),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .pin_pu    (pin_pu),
   .chg_flag  (chg_flag),
   .ext_flag  (ext_flag)
);

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       wr_data = 0, wr_dir = 0, rd_port = 0, rd_dir = 0;
   logic       pu_en_n = 1, ext_rise = 1, chg_clr = 0, ext_clr = 0;
   logic [7:0] pin_in = '0;
   logic [7:0] rd_data, pin_out, pin_oe, pin_pu;
   logic       chg_flag, ext_flag;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   gpio_chg_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_data(wr_data),
      .wr_dir(wr_dir), .rd_port(rd_port), .rd_dir(rd_dir), .rd_data(rd_data),
      .pu_en_n(pu_en_n), .ext_rise(ext_rise), .chg_clr(chg_clr), .ext_clr(ext_clr),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
      .chg_flag(chg_flag), .ext_flag(ext_flag)
   );

   // {direction, data, pins, expected read, expected oe}
   localparam logic [39:0] VEC [6] = '{
      {8'hFF, 8'h00, 8'hA5, 8'hA5, 8'h00},
      {8'h00, 8'h3C, 8'hFF, 8'h3C, 8'hFF},
      {8'hF0, 8'h0F, 8'h55, 8'h5F, 8'h0F},
      {8'h0F, 8'hAA, 8'h33, 8'hA3, 8'hF0},
      {8'h81, 8'h7E, 8'h00, 8'h7E, 8'h7E},
      {8'h5A, 8'hC3, 8'h96, 8'h93, 8'hA5}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_dir(input logic [7:0] v);
      bus_wdata = v; wr_dir = 1; cyc(1); wr_dir = 0;
   endtask

   task automatic write_data(input logic [7:0] v);
      bus_wdata = v; wr_data = 1; cyc(1); wr_data = 0;
   endtask

   task automatic pulse_read;
      rd_port = 1; cyc(1); rd_port = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1;
      cyc(1);
      // R1 reset state
      chk("R1 pin_oe", pin_oe, 8'h00);
      chk("R1 pin_out", pin_out, 8'h00);
      chk("R1 pin_pu", pin_pu, 8'h00);
      chk("R1 flags", {6'd0, chg_flag, ext_flag}, 8'h00);
      rd_dir = 1; #1;
      chk("R1 R12 dir readback", rd_data, 8'hFF);
      rd_dir = 0; #1;
      chk("R12 no strobe", rd_data, 8'h00);

      // table: R3 R5 mixed directions
      foreach (VEC[k]) begin
         write_dir(VEC[k][39:32]);
         pin_in = VEC[k][23:16];
         write_data(VEC[k][31:24]);
         chk("R2 pin_out", pin_out, VEC[k][31:24]);
         cyc(2);
         chk("R3 pin_oe", pin_oe, VEC[k][7:0]);
         rd_port = 1; #1;
         chk("R5 port read", rd_data, VEC[k][15:8]);
         rd_dir = 1; #1;
         chk("R12 port over dir", rd_data, VEC[k][15:8]);
         rd_port = 0; #1;
         chk("R12 dir read", rd_data, VEC[k][39:32]);
         rd_dir = 0;
         cyc(1);
      end

      // R4 pull-ups
      write_dir(8'hF0);
      pu_en_n = 0; #1;
      chk("R4 pu enabled", pin_pu, 8'hF0);
      pu_en_n = 1; #1;
      chk("R4 pu global off", pin_pu, 8'h00);

      // R5 synchronizer latency
      write_dir(8'hFF);
      pin_in = 8'h00; cyc(3);
      pin_in = 8'h81; cyc(1);
      rd_port = 1; #1;
      chk("R5 one edge", rd_data, 8'h00);
      rd_port = 0; cyc(1);
      rd_port = 1; #1;
      chk("R5 two edges", rd_data, 8'h81);
      rd_port = 0;

      // R6 change detection timing
      pin_in = 8'h00; cyc(3);
      pulse_read;
      chg_clr = 1; ext_clr = 1; cyc(1); chg_clr = 0; ext_clr = 0;
      chk("R10 clean start", {7'd0, chg_flag}, 8'h00);
      pin_in = 8'h10;
      cyc(3);
      chk("R6 before 4th edge", {7'd0, chg_flag}, 8'h00);
      cyc(1);
      chk("R6 set", {7'd0, chg_flag}, 8'h01);
      // R9 set beats clear while mismatch lives
      chg_clr = 1; cyc(1); chg_clr = 0;
      chk("R9 clear ignored in mismatch", {7'd0, chg_flag}, 8'h01);
      cyc(3);
      chk("R9 sticky", {7'd0, chg_flag}, 8'h01);
      // R10 read ends mismatch
      pulse_read;
      chg_clr = 1; cyc(1); chg_clr = 0;
      chk("R10 cleared after read", {7'd0, chg_flag}, 8'h00);
      cyc(4);
      chk("R10 stays clear", {7'd0, chg_flag}, 8'h00);

      // R7 low bits ignored
      pin_in = 8'h1F; cyc(6);
      chk("R7 low bits", {7'd0, chg_flag}, 8'h00);
      pin_in = 8'h10; cyc(6);
      chk("R7 low bits back", {7'd0, chg_flag}, 8'h00);

      // R8 output bits excluded
      write_dir(8'h0F);
      pin_in = 8'hF0; cyc(6);
      chk("R8 outputs excluded", {7'd0, chg_flag}, 8'h00);
      write_dir(8'hFF);
      cyc(1);
      chk("R8 re-enabled input", {7'd0, chg_flag}, 8'h01);
      pulse_read;
      chg_clr = 1; cyc(1); chg_clr = 0;
      chk("R10 clear again", {7'd0, chg_flag}, 8'h00);

      // R11 edge interrupt
      ext_rise = 1; cyc(4);
      ext_clr = 1; cyc(1); ext_clr = 0;
      chk("R11 clear", {7'd0, ext_flag}, 8'h00);
      pin_in = 8'hF1;
      cyc(2);
      chk("R11 rise before 3rd edge", {7'd0, ext_flag}, 8'h00);
      cyc(1);
      chk("R11 rise set", {7'd0, ext_flag}, 8'h01);
      cyc(3);
      chk("R11 sticky", {7'd0, ext_flag}, 8'h01);
      ext_rise = 0;
      ext_clr = 1; cyc(1); ext_clr = 0;
      cyc(2);
      chk("R11 cleared", {7'd0, ext_flag}, 8'h00);
      pin_in = 8'hF0;
      cyc(2);
      chk("R11 fall before 3rd edge", {7'd0, ext_flag}, 8'h00);
      cyc(1);
      chk("R11 fall set", {7'd0, ext_flag}, 8'h01);
      ext_clr = 1; cyc(1); ext_clr = 0;
      pin_in = 8'hF1; cyc(5);
      chk("R11 rise ignored when falling", {7'd0, ext_flag}, 8'h00);
      chk("R7 bit0 no change flag", {7'd0, chg_flag}, 8'h00);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule